// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block produces one bus cycle at a time toward an 8-bit NAND Flash device. A cycle can carry a command byte, an address byte, a write-data byte, or a read. Every phase of the cycle is counted in system clock cycles. The requester offers a cycle on a valid/ready handshake. Along with the cycle type and the byte, it supplies four timing values:

- a lead-in value: how long chip select and the latch enables settle before the strobe falls;
- a strobe value: the minimum time the strobe stays low;
- a trailing value: how long the bus and latch enables stay put after the strobe rises;
- a turnaround value: how long the shared bus stays released at the start of a data write.

Back-pressure works as follows. `req_ready` is high only while no cycle is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The type, byte and all four timing values are captured on that edge. Changes to them during the cycle have no effect. The requester may hold `req_valid` high for as long as it likes. Read data comes back on a one-cycle `rd_valid` pulse, and that pulse cannot be stalled. The device's ready/busy line stretches the strobe while the device is busy. Address cycles can be chained without limit to build addresses of any length.

The shared bus uses split pad signals: a drive value, a drive enable and a sampled input.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset and between cycles, chip select, read strobe and write strobe are high. Both latch enables are low, the bus is released (`nand_dq_oe`=0), `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low from the next cycle until the last trailing cycle has passed. Inputs that change after the taking edge do not affect that cycle.
- R3: In the cycle after a request is taken, chip select falls. It stays low with the strobe high for exactly `cfg_setup`+1 cycles (1 to 256).
- R4: With ready/busy high, the strobe stays low for exactly max(`cfg_wait`,2) cycles (2 to 255).
- R5: While `nand_rb` is 0 (busy) at the end of a strobe cycle, the strobe stays low for one more cycle, even past its programmed minimum.
- R6: After the strobe rises, chip select, the latch enables and the driven bus value are held for exactly `cfg_hold` cycles, with 0 treated as 1 and 255 treated as 254. `req_ready` then rises in the following cycle.
- R7: On a data write (op 2'b10), the bus stays released for the first max(`cfg_hiz`,1) cycles of the access. After that it drives the byte until the cycle ends. Command and address cycles drive the byte from the first cycle. A read never drives the bus. The driven value does not change while the drive enable stays high.
- R8: `nand_cle` is high during the whole of a command cycle (op 2'b00). `nand_ale` is high during the whole of an address cycle (op 2'b01). Neither is high for op 2'b10 or 2'b11.
- R9: Command, address and write cycles (ops 2'b00, 2'b01, 2'b10) use the write strobe. A read (op 2'b11) uses the read strobe. The two strobes are never low together.
- R10: On a read, `nand_dq_i` is sampled in the last strobe-low cycle. It appears on `rd_data` with a one-cycle `rd_valid` pulse in the first trailing cycle.
- R11: Address cycles may follow each other with no limit on their number. Each one is timed on its own and carries its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| req_byte | input | 8 | Byte to drive for command, address or write |
| cfg_setup | input | 8 | Lead-in length minus one |
| cfg_wait | input | 8 | Minimum strobe length (values below 2 act as 2) |
| cfg_hold | input | 8 | Trailing length (0 acts as 1, 255 as 254) |
| cfg_hiz | input | 8 | Bus release at start of a write (0 acts as 1) |
| rd_valid | output | 1 | One-cycle pulse, read byte available |
| rd_data | output | 8 | Byte captured by a read |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dq_o | output | 8 | Bus drive value |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus sampled value |
| nand_rb | input | 1 | Device ready (1) or busy (0) |

## Verification
A phase counter or phase register that goes wrong shows at the pins within one cycle. Chip select, a strobe or `req_ready` moves one cycle early or late compared with the lengths programmed at the taking edge. A fault in the turnaround count shows as the write-drive enable rising in the wrong cycle. A fault in read capture or busy handling shows as a wrong `rd_data` or a misplaced `rd_valid` pulse in the first trailing cycle. The reference model expects a value for every pin in every cycle of each access, so any of these faults shows up on the first clock where it touches a pin.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'b00,
    OP_ADDR = 2'b01,
    OP_WR   = 2'b10,
    OP_RD   = 2'b11
  } nand_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_SETUP = 2'b01,
    PH_WAIT  = 2'b10,
    PH_HOLD  = 2'b11
  } nand_phase_e;

endpackage

// File: rtl/nand_phase_timer.sv
// Saturating up-counter, cleared on demand; flags when the count reaches a limit.
module nand_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] last,
  output logic         reached
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clear)            count <= '0;
    else if (count != CNT_MAX) count <= count + W'(1);
  end

  assign reached = (count >= last);

endmodule

// File: rtl/nand_pin_drive.sv
// Maps the sequencer phase and the captured request onto the device pins.
module nand_pin_drive
  import nand_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  nand_phase_e     phase,
  input  nand_op_e        op,
  input  logic [DW-1:0]   byte_q,
  input  logic            hz_done,
  output logic            ce_n,
  output logic            re_n,
  output logic            we_n,
  output logic            cle,
  output logic            ale,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe
);
  logic active;
  logic strobe;

  always_comb begin
    active = (phase != PH_IDLE);
    strobe = (phase == PH_WAIT);
    ce_n   = !active;
    re_n   = !(strobe && op == OP_RD);
    we_n   = !(strobe && op != OP_RD);
    cle    = active && (op == OP_CMD);
    ale    = active && (op == OP_ADDR);
    unique case (op)
      OP_CMD, OP_ADDR: dq_oe = active;
      OP_WR:           dq_oe = active && hz_done;
      default:         dq_oe = 1'b0;
    endcase
    dq_o = dq_oe ? byte_q : '0;
  end

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_byte,
  input  logic [TIME_W-1:0] cfg_setup,
  input  logic [TIME_W-1:0] cfg_wait,
  input  logic [TIME_W-1:0] cfg_hold,
  input  logic [TIME_W-1:0] cfg_hiz,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              nand_ce_n,
  output logic              nand_re_n,
  output logic              nand_we_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_i,
  input  logic              nand_rb
);
  localparam logic [TIME_W-1:0] ONE      = TIME_W'(1);
  localparam logic [TIME_W-1:0] WAIT_MIN = TIME_W'(2);
  localparam logic [TIME_W-1:0] HOLD_MAX = TIME_W'((2 ** TIME_W) - 2);

  nand_phase_e       phase;
  nand_op_e          op_q;
  logic [DATA_W-1:0] byte_q;
  logic [TIME_W-1:0] setup_last, wait_last, hold_last, hiz_len;
  logic [TIME_W-1:0] wait_len, hold_len, tmr_last;
  logic              accept, advance, tmr_reached, hz_done;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  // Clamp the programmed lengths into their legal ranges at capture time.
  always_comb begin
    wait_len = (cfg_wait < WAIT_MIN) ? WAIT_MIN : cfg_wait;
    if (cfg_hold == '0)          hold_len = ONE;
    else if (cfg_hold > HOLD_MAX) hold_len = HOLD_MAX;
    else                          hold_len = cfg_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_CMD;
      byte_q     <= '0;
      setup_last <= '0;
      wait_last  <= '0;
      hold_last  <= '0;
      hiz_len    <= ONE;
    end else if (accept) begin
      op_q       <= nand_op_e'(req_op);
      byte_q     <= req_byte;
      setup_last <= cfg_setup;
      wait_last  <= wait_len - ONE;
      hold_last  <= hold_len - ONE;
      hiz_len    <= (cfg_hiz == '0) ? ONE : cfg_hiz;
    end
  end

  always_comb begin
    unique case (phase)
      PH_SETUP: tmr_last = setup_last;
      PH_WAIT:  tmr_last = wait_last;
      PH_HOLD:  tmr_last = hold_last;
      default:  tmr_last = '0;
    endcase
    unique case (phase)
      PH_SETUP, PH_HOLD: advance = tmr_reached;
      PH_WAIT:           advance = tmr_reached && nand_rb;
      default:           advance = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:  if (accept)  phase <= PH_SETUP;
        PH_SETUP: if (advance) phase <= PH_WAIT;
        PH_WAIT:  if (advance) phase <= PH_HOLD;
        default:  if (advance) phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (phase == PH_WAIT && advance && op_q == OP_RD) begin
        rd_valid <= 1'b1;
        rd_data  <= nand_dq_i;
      end
    end
  end

  nand_phase_timer #(.W(TIME_W)) i_phase_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept || advance),
    .last    (tmr_last),
    .reached (tmr_reached)
  );

  nand_phase_timer #(.W(TIME_W)) i_hiz_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .last    (hiz_len),
    .reached (hz_done)
  );

  nand_pin_drive #(.DW(DATA_W)) i_pins (
    .phase   (phase),
    .op      (op_q),
    .byte_q  (byte_q),
    .hz_done (hz_done),
    .ce_n    (nand_ce_n),
    .re_n    (nand_re_n),
    .we_n    (nand_we_n),
    .cle     (nand_cle),
    .ale     (nand_ale),
    .dq_o    (nand_dq_o),
    .dq_oe   (nand_dq_oe)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && nand_re_n && nand_we_n && !nand_dq_oe));
  // R3
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_re_n || !nand_we_n) |-> !nand_ce_n);
  // R5
  busy_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!nand_re_n || !nand_we_n) && !nand_rb) |=> (!nand_re_n || !nand_we_n));
  // R7
  bus_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_dq_oe && $past(nand_dq_oe)) |-> $stable(nand_dq_o));
  // R8
  one_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [1:0] req_op;
  logic [7:0] req_byte, cfg_setup, cfg_wait, cfg_hold, cfg_hiz;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       nand_ce_n, nand_re_n, nand_we_n, nand_cle, nand_ale;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic       nand_dq_oe, nand_rb;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  nand_cycle_seq i_nand_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_byte(req_byte), .cfg_setup(cfg_setup),
    .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_hiz(cfg_hiz),
    .rd_valid(rd_valid), .rd_data(rd_data), .nand_ce_n(nand_ce_n),
    .nand_re_n(nand_re_n), .nand_we_n(nand_we_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R1: quiet pins between cycles
  task automatic chk_idle(input string tag);
    chk(tag, "req_ready", int'(req_ready), 1);
    chk(tag, "ce_n", int'(nand_ce_n), 1);
    chk(tag, "re_n", int'(nand_re_n), 1);
    chk(tag, "we_n", int'(nand_we_n), 1);
    chk(tag, "cle", int'(nand_cle), 0);
    chk(tag, "ale", int'(nand_ale), 0);
    chk(tag, "dq_oe", int'(nand_dq_oe), 0);
    chk(tag, "rd_valid", int'(rd_valid), 0);
  endtask

  // Behavioural reference: derive every pin per cycle from the requested lengths.
  task automatic run_op(input int op, input int b, input int s_raw, input int w_raw,
                        input int h_raw, input int t_raw, input int busy_len, input int rdv);
    int s_len = s_raw + 1;
    int w_len = (w_raw < 2) ? 2 : w_raw;
    int h_len = (h_raw == 0) ? 1 : ((h_raw > 254) ? 254 : h_raw);
    int t_len = (t_raw == 0) ? 1 : t_raw;
    int last_strobe = s_len + w_len - 1;
    if (busy_len > last_strobe) last_strobe = busy_len;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_byte = 8'(b);
    cfg_setup = 8'(s_raw); cfg_wait = 8'(w_raw); cfg_hold = 8'(h_raw); cfg_hiz = 8'(t_raw);
    nand_rb = (busy_len > 0) ? 1'b0 : 1'b1;
    chk("R2", "ready before take", int'(req_ready), 1);
    for (int k = 0; k <= last_strobe + h_len; k++) begin
      string tag;
      bit in_strobe;
      bit oe_exp;
      @(negedge clk);
      if (k == 0) begin
        // R2: changed inputs must not disturb the cycle in flight
        req_valid = 1'b0; req_byte = 8'(~b); req_op = 2'(op + 1);
        cfg_setup = 8'd0; cfg_wait = 8'd0; cfg_hold = 8'd0; cfg_hiz = 8'd0;
      end
      nand_rb   = (k < busy_len) ? 1'b0 : 1'b1;
      nand_dq_i = 8'(rdv);
      in_strobe = (k >= s_len) && (k <= last_strobe);
      if (k < s_len) tag = "R3";
      else if (k <= last_strobe) tag = (k > s_len + w_len - 1) ? "R5" : "R4";
      else tag = "R6";
      chk("R2", "req_ready busy", int'(req_ready), 0);
      chk(tag, "ce_n", int'(nand_ce_n), 0);
      // R9: strobe choice by op
      chk(tag, "we_n", int'(nand_we_n), (in_strobe && op != 3) ? 0 : 1);
      chk(tag, "re_n", int'(nand_re_n), (in_strobe && op == 3) ? 0 : 1);
      chk("R8", "cle", int'(nand_cle), (op == 0) ? 1 : 0);
      chk("R8", "ale", int'(nand_ale), (op == 1) ? 1 : 0);
      oe_exp = (op == 0) || (op == 1) || (op == 2 && k >= t_len);
      chk("R7", "dq_oe", int'(nand_dq_oe), int'(oe_exp));
      if (oe_exp) chk("R7", "dq_o", int'(nand_dq_o), b & 8'hFF);
      chk("R10", "rd_valid", int'(rd_valid), (op == 3 && k == last_strobe + 1) ? 1 : 0);
      if (op == 3 && k == last_strobe + 1) chk("R10", "rd_data", int'(rd_data), rdv & 8'hFF);
    end
    @(negedge clk);
    chk_idle("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_byte = 8'd0;
    cfg_setup = 8'd0; cfg_wait = 8'd2; cfg_hold = 8'd1; cfg_hiz = 8'd1;
    nand_dq_i = 8'd0; nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");

    run_op(0, 8'h70, 0, 2, 1, 1, 0, 0);        // shortest command cycle
    run_op(1, 8'h12, 3, 5, 2, 1, 0, 0);        // address cycle
    // R11: chained address cycles, each with its own byte and timing
    for (int i = 0; i < 6; i++) run_op(1, 8'h30 + i, i, 2 + i, 1 + (i % 3), 1, 0, 0);
    run_op(2, 8'hC3, 1, 3, 2, 3, 0, 0);        // write, bus released 3 cycles
    run_op(2, 8'h5A, 1, 3, 3, 10, 0, 0);       // write, release outlasts cycle
    run_op(2, 8'h99, 0, 4, 2, 0, 0, 0);        // hiz 0 acts as 1
    run_op(3, 0, 2, 4, 2, 1, 0, 8'hA5);        // read
    run_op(3, 0, 1, 3, 1, 1, 12, 8'h3C);       // read stretched by busy (R5)
    run_op(2, 8'h81, 0, 2, 1, 2, 6, 0);        // write stretched by busy
    run_op(0, 8'hFF, 0, 0, 0, 1, 0, 0);        // wait 0 -> 2, hold 0 -> 1
    run_op(1, 8'h01, 255, 255, 255, 1, 0, 0);  // longest lengths, hold 255 -> 254
    run_op(3, 0, 0, 2, 1, 1, 2, 8'h00);        // busy ends at minimum

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule